// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block decides when DRAM refresh happens. A free-running clock enable passes through two programmable dividers in series. The first is a prescaler and the second is a periodic timer. Each time the second divider runs out, the block raises a refresh request toward the memory controller.

Once the controller grants the request, the block counts refresh beats as the controller reports each one done. It tells the controller which bank the current beat belongs to. When every beat for one bank has finished, it moves to the next bank. After the last bank it returns to idle.

A timeout that arrives while a burst is still running is remembered once. It is served as soon as the running burst ends.

The block makes no DRAM command waveforms. It only schedules refresh work.

The second divisor is normally chosen as refresh period × beats per burst ÷ (rows × enable period × prescaler × banks), rounded down. Take a 16 ms period, 4 beats, 1024 rows, a 20 ns enable, a prescaler of 16 and 2 banks. That gives 97, so a request appears every 1552 enables.

Top module: `refresh_req_timer`

## Requirements
- R1: The prescaler gives one output for every `pre_div` enables (`tick_en` high). A value below 2 acts as 2, and a value above 64 acts as 64.
- R2: The period timer gives one refresh trigger for every `per_div` prescaler outputs. With `per_div` = 0 no trigger, and so no request, is ever produced.
- R3: With prescaler 16 and period divisor 97, a request appears after exactly 1552 enables since the dividers were last cleared.
- R4: A changed divisor is first used when its divider next wraps (reloads). The interval in progress finishes with the old value.
- R5: `ref_req` goes high in the cycle after the enable that causes a trigger. It stays high until `ref_grant` is seen, and drops in the cycle after the grant.
- R6: After a grant, every `ref_done` counts one beat, and `beat_stb` is high in that same cycle. The beats per bank are `beats`, where 0 acts as 1 and values above 16 act as 16.
- R7: `ref_bank` is 0 when a request rises. It moves to the next bank after the last beat of the current bank, for `banks` banks (0 acts as 1, above 4 acts as 4). It returns to 0 when the burst ends.
- R8: A trigger that arrives during a request or burst is kept as one pending request. Its request rises two cycles after the burst's last done. Any further triggers in that time are dropped.
- R9: A synchronous reset (`rst` high) clears both dividers, the beat count and the bank index, and drops `ref_req`. The divisors in force afterwards are the values present during reset.
- R10: A `ref_done` while no burst is granted is ignored: `beat_stb` stays low and the beat and bank counts do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Clock enable that feeds the prescaler |
| pre_div | input | 7 | Prescaler divisor |
| per_div | input | 8 | Period timer divisor, 0 turns refresh off |
| beats | input | 5 | Refresh beats per bank |
| banks | input | 3 | Number of banks to visit per burst |
| ref_grant | input | 1 | Controller accepts the pending request |
| ref_done | input | 1 | Controller finished one refresh beat |
| ref_req | output | 1 | Refresh request |
| ref_bank | output | 2 | Bank of the current beat |
| beat_stb | output | 1 | Marks each completed beat |

## Verification
The riskiest coincidence is a period timeout landing in the same cycle as the last done of a burst. In that cycle the sequencer both closes the burst and records a new trigger.

The bench sets this up on purpose. It pre-counts the prescaler to one enable short of a wrap, then drives the final `ref_done` and the wrapping `tick_en` together. The trigger must not be lost: a fresh request must rise exactly two cycles after that shared edge, starting at bank 0. The same timing is also checked when the trigger arrives earlier in the burst, so the two cases can be compared.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_RUN  = 2'd2
   } rrt_state_e;
endpackage

// File: rtl/rrt_divider.sv
module rrt_divider #(
   parameter int W        = 8,
   parameter int MIN_DIV  = 1,
   parameter int MAX_DIV  = 255,
   parameter bit ZERO_OFF = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick_i,
   input  logic [W-1:0] div_i,
   output logic         pulse_o
);
   if (MIN_DIV < 1)            $error("rrt_divider: MIN_DIV must be at least 1");
   if (MAX_DIV > (2**W) - 1)   $error("rrt_divider: MAX_DIV does not fit in W bits");
   if (MIN_DIV > MAX_DIV)      $error("rrt_divider: MIN_DIV above MAX_DIV");

   logic [W-1:0] eff;
   logic [W-1:0] lim;
   logic [W-1:0] cnt;

   if (ZERO_OFF) begin : g_off
      always_comb begin
         if (div_i == '0)                      eff = '0;
         else if (div_i < W'(MIN_DIV))         eff = W'(MIN_DIV);
         else if (div_i > W'(MAX_DIV))         eff = W'(MAX_DIV);
         else                                  eff = div_i;
      end
   end else begin : g_clamp
      always_comb begin
         if (div_i < W'(MIN_DIV))              eff = W'(MIN_DIV);
         else if (div_i > W'(MAX_DIV))         eff = W'(MAX_DIV);
         else                                  eff = div_i;
      end
   end

   assign pulse_o = tick_i && (lim != '0) && (cnt == lim - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         lim <= eff;
      end else if (tick_i) begin
         if (lim == '0) begin
            lim <= eff;
         end else if (cnt == lim - 1'b1) begin
            cnt <= '0;
            lim <= eff;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rrt_burst_seq.sv
module rrt_burst_seq
   import rrt_pkg::*;
#(
   parameter int MAX_BEATS = 16,
   parameter int NUM_BANKS = 4,
   localparam int BEAT_IW  = $clog2(MAX_BEATS + 1),
   localparam int BANK_IW  = $clog2(NUM_BANKS + 1),
   localparam int BANK_SW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig_i,
   input  logic [BEAT_IW-1:0] beats_i,
   input  logic [BANK_IW-1:0] banks_i,
   input  logic               grant_i,
   input  logic               done_i,
   output logic               req_o,
   output logic [BANK_SW-1:0] bank_o,
   output logic               beat_stb_o
);
   localparam int BEAT_CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

   if (MAX_BEATS < 1) $error("rrt_burst_seq: MAX_BEATS must be at least 1");
   if (NUM_BANKS < 1) $error("rrt_burst_seq: NUM_BANKS must be at least 1");

   rrt_state_e         state;
   logic               pend;
   logic [BEAT_CW-1:0] beat_cnt;
   logic [BEAT_CW-1:0] beat_last;
   logic [BANK_SW-1:0] bank_last;
   logic [BEAT_IW-1:0] beats_eff;
   logic [BANK_IW-1:0] banks_eff;

   always_comb begin
      if (beats_i == '0)                     beats_eff = BEAT_IW'(1);
      else if (beats_i > BEAT_IW'(MAX_BEATS)) beats_eff = BEAT_IW'(MAX_BEATS);
      else                                   beats_eff = beats_i;
      if (banks_i == '0)                     banks_eff = BANK_IW'(1);
      else if (banks_i > BANK_IW'(NUM_BANKS)) banks_eff = BANK_IW'(NUM_BANKS);
      else                                   banks_eff = banks_i;
   end

   assign req_o      = (state == SEQ_REQ);
   assign beat_stb_o = (state == SEQ_RUN) && done_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= SEQ_IDLE;
         pend      <= 1'b0;
         beat_cnt  <= '0;
         bank_o    <= '0;
         beat_last <= '0;
         bank_last <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (trig_i || pend) begin
                  state     <= SEQ_REQ;
                  pend      <= 1'b0;
                  beat_cnt  <= '0;
                  bank_o    <= '0;
                  beat_last <= BEAT_CW'(beats_eff - 1'b1);
                  bank_last <= BANK_SW'(banks_eff - 1'b1);
               end
            end
            SEQ_REQ: begin
               if (trig_i)  pend  <= 1'b1;
               if (grant_i) state <= SEQ_RUN;
            end
            SEQ_RUN: begin
               if (trig_i) pend <= 1'b1;
               if (done_i) begin
                  if (beat_cnt == beat_last) begin
                     beat_cnt <= '0;
                     if (bank_o == bank_last) begin
                        bank_o <= '0;
                        state  <= SEQ_IDLE;
                     end else begin
                        bank_o <= bank_o + 1'b1;
                     end
                  end else begin
                     beat_cnt <= beat_cnt + 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
   parameter int PRE_W     = 7,
   parameter int PRE_MAX   = 64,
   parameter int PER_W     = 8,
   parameter int MAX_BEATS = 16,
   parameter int NUM_BANKS = 4
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic                                         tick_en,
   input  logic [PRE_W-1:0]                             pre_div,
   input  logic [PER_W-1:0]                             per_div,
   input  logic [$clog2(MAX_BEATS+1)-1:0]               beats,
   input  logic [$clog2(NUM_BANKS+1)-1:0]               banks,
   input  logic                                         ref_grant,
   input  logic                                         ref_done,
   output logic                                         ref_req,
   output logic [((NUM_BANKS>1)?$clog2(NUM_BANKS):1)-1:0] ref_bank,
   output logic                                         beat_stb
);
   localparam int PER_MAX = (2**PER_W) - 1;

   if (PRE_MAX < 2) $error("refresh_req_timer: PRE_MAX must be at least 2");

   logic pre_pulse;
   logic trig;

   rrt_divider #(
      .W(PRE_W), .MIN_DIV(2), .MAX_DIV(PRE_MAX), .ZERO_OFF(1'b0)
   ) u_pre (
      .clk(clk), .rst(rst), .tick_i(tick_en), .div_i(pre_div), .pulse_o(pre_pulse)
   );

   rrt_divider #(
      .W(PER_W), .MIN_DIV(1), .MAX_DIV(PER_MAX), .ZERO_OFF(1'b1)
   ) u_per (
      .clk(clk), .rst(rst), .tick_i(pre_pulse), .div_i(per_div), .pulse_o(trig)
   );

   rrt_burst_seq #(
      .MAX_BEATS(MAX_BEATS), .NUM_BANKS(NUM_BANKS)
   ) u_seq (
      .clk(clk), .rst(rst), .trig_i(trig), .beats_i(beats), .banks_i(banks),
      .grant_i(ref_grant), .done_i(ref_done),
      .req_o(ref_req), .bank_o(ref_bank), .beat_stb_o(beat_stb)
   );
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
   parameter int BANK_SW = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               ref_req,
   input logic               ref_grant,
   input logic               ref_done,
   input logic               beat_stb,
   input logic [BANK_SW-1:0] ref_bank
);
   AST_RST_CLEARS: assert property (@(posedge clk)
      rst |=> (!ref_req && ref_bank == '0));                                   // R9
   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (ref_req && !ref_grant) |=> ref_req);                                    // R5
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
      (ref_req && ref_grant) |=> !ref_req);                                    // R5
   AST_STB_ON_DONE: assert property (@(posedge clk) disable iff (rst)
      beat_stb |-> (ref_done && !ref_req));                                    // R6
   AST_BANK_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!rst && !beat_stb) |=> $stable(ref_bank));                              // R7
   AST_REQ_BANK0: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_req) |-> (ref_bank == '0));                                    // R7
endmodule

bind refresh_req_timer rrt_checker #(
   .BANK_SW((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)
) u_chk (
   .clk(clk), .rst(rst), .ref_req(ref_req), .ref_grant(ref_grant),
   .ref_done(ref_done), .beat_stb(beat_stb), .ref_bank(ref_bank)
);

// File: tb/refresh_req_timer_tb_top.sv
module refresh_req_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_en = 1'b0;
   logic [6:0] pre_div = 7'd2;
   logic [7:0] per_div = 8'd1;
   logic [4:0] beats = 5'd1;
   logic [2:0] banks = 3'd1;
   logic       ref_grant = 1'b0;
   logic       ref_done = 1'b0;
   logic       ref_req;
   logic [1:0] ref_bank;
   logic       beat_stb;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   refresh_req_timer dut_i (
      .clk(clk), .rst(rst), .tick_en(tick_en), .pre_div(pre_div), .per_div(per_div),
      .beats(beats), .banks(banks), .ref_grant(ref_grant), .ref_done(ref_done),
      .ref_req(ref_req), .ref_bank(ref_bank), .beat_stb(beat_stb)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic grant();
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
   endtask

   task automatic done_one(input string tag, input int exp_bank);
      ref_done = 1'b1;
      #1;
      chk({tag, " beat_stb"}, beat_stb, 1);
      chk({tag, " bank"}, ref_bank, exp_bank);
      @(negedge clk);
      ref_done = 1'b0;
   endtask

   task automatic cfg(input int p, input int q, input int b, input int k);
      pre_div = 7'(p); per_div = 8'(q); beats = 5'(b); banks = 3'(k);
   endtask

   task automatic t_reset();
      cfg(2, 1, 1, 1);
      do_reset();
      chk("R9 req after reset", ref_req, 0);
      chk("R9 bank after reset", ref_bank, 0);
      chk("R9 stb after reset", beat_stb, 0);
   endtask

   task automatic t_prescale();
      cfg(3, 1, 1, 1); do_reset();
      ticks(2); chk("R1 div3 early", ref_req, 0);
      ticks(1); chk("R1 div3 at 3", ref_req, 1);
      grant(); done_one("R1 svc", 0);
      cfg(0, 1, 1, 1); do_reset();
      ticks(1); chk("R1 div0 as 2 early", ref_req, 0);
      ticks(1); chk("R1 div0 as 2", ref_req, 1);
      grant(); done_one("R1 svc", 0);
      cfg(100, 1, 1, 1); do_reset();
      ticks(63); chk("R1 div100 as 64 early", ref_req, 0);
      ticks(1);  chk("R1 div100 as 64", ref_req, 1);
      grant(); done_one("R1 svc", 0);
   endtask

   task automatic t_period();
      cfg(2, 3, 1, 1); do_reset();
      ticks(5); chk("R2 per3 early", ref_req, 0);
      ticks(1); chk("R2 per3 at 6", ref_req, 1);
      grant(); done_one("R2 svc", 0);
      cfg(2, 0, 1, 1); do_reset();
      ticks(300); chk("R2 per0 off", ref_req, 0);
   endtask

   task automatic t_change();
      cfg(2, 1, 1, 1); do_reset();
      ticks(1);
      pre_div = 7'd5;
      ticks(1); chk("R4 old divisor kept", ref_req, 1);
      grant(); done_one("R4 svc", 0);
      ticks(4); chk("R4 new divisor early", ref_req, 0);
      ticks(1); chk("R4 new divisor used", ref_req, 1);
      grant(); done_one("R4 svc", 0);
   endtask

   task automatic t_example();
      cfg(16, 97, 4, 2); do_reset();
      for (int rep = 0; rep < 2; rep++) begin
         ticks(1551); chk("R3 interval 1551", ref_req, 0);
         ticks(1);    chk("R3 interval 1552", ref_req, 1);
         grant();
         for (int d = 0; d < 8; d++) done_one("R3 burst", d / 4);
         chk("R3 burst end req", ref_req, 0);
         chk("R3 burst end bank", ref_bank, 0);
      end
   endtask

   task automatic t_burst();
      cfg(2, 1, 3, 3); do_reset();
      ticks(1); chk("R5 no req before trigger", ref_req, 0);
      ticks(1); chk("R5 req after trigger", ref_req, 1);
      idle(5);  chk("R5 req held", ref_req, 1);
      ref_done = 1'b1; #1;
      chk("R10 done before grant", beat_stb, 0);
      @(negedge clk); ref_done = 1'b0;
      grant(); chk("R5 req drops after grant", ref_req, 0);
      for (int d = 0; d < 9; d++) done_one("R7 bank order", d / 3);
      chk("R7 bank back to 0", ref_bank, 0);
      chk("R7 no req after burst", ref_req, 0);
      ref_done = 1'b1; #1;
      chk("R10 done when idle", beat_stb, 0);
      @(negedge clk); ref_done = 1'b0;
      chk("R10 bank unchanged", ref_bank, 0);
      ticks(2); chk("R10 next req", ref_req, 1);
      grant();
      for (int d = 0; d < 9; d++) done_one("R10 count intact", d / 3);
   endtask

   task automatic t_clamp();
      cfg(2, 1, 20, 2); do_reset();
      ticks(2); grant();
      for (int d = 0; d < 15; d++) done_one("R6 beats20 as 16", 0);
      done_one("R6 beats20 16th", 0);
      chk("R6 bank after 16 beats", ref_bank, 1);
      done_one("R6 second bank", 1);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      chk("R9 mid-burst req", ref_req, 0);
      chk("R9 mid-burst bank", ref_bank, 0);
      cfg(2, 1, 0, 7); do_reset();
      ticks(2); grant();
      done_one("R6 beats0 as 1", 0);
      chk("R6 bank after 1 beat", ref_bank, 1);
      done_one("R7 banks7 as 4", 1);
      done_one("R7 banks7 as 4", 2);
      done_one("R7 banks7 as 4", 3);
      chk("R7 four banks done", ref_bank, 0);
      idle(1);
      chk("R7 burst over", ref_req, 0);
   endtask

   task automatic t_pending();
      cfg(2, 1, 1, 1); do_reset();
      ticks(2); chk("R8 first req", ref_req, 1);
      ticks(2); chk("R8 req unchanged", ref_req, 1);
      grant();
      ticks(4);
      done_one("R8 end burst", 0);
      chk("R8 gap cycle", ref_req, 0);
      idle(1); chk("R8 pending served", ref_req, 1);
      grant(); done_one("R8 pending burst", 0);
      idle(6); chk("R8 no stacking", ref_req, 0);
      ticks(2); grant();
      ticks(1);
      tick_en = 1'b1;
      done_one("R8 coincident done", 0);
      tick_en = 1'b0;
      chk("R8 coincident gap", ref_req, 0);
      idle(1); chk("R8 coincident trigger kept", ref_req, 1);
      chk("R8 coincident bank", ref_bank, 0);
      grant(); done_one("R8 svc", 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_prescale();
      t_period();
      t_change();
      t_example();
      t_burst();
      t_clamp();
      t_pending();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule